// File: doc/BRIEF.md
# Sixteen-Channel Time-Shared Serial Port

This block provides sixteen independent asynchronous serial channels without building sixteen separate transceivers. A single bit engine serves one channel per clock, in fixed rotation. At each visit it reads that channel's context word from a small state memory, advances its transmitter and receiver by one step, and writes the word back. The context word holds the oversample counter, the shift registers, the bit and phase counters, and the last sampled line level. The pins are serial data out and in, plus two flow-control lines per channel.

Each channel buffers one character in each direction in a holding register. A host reaches these registers through a channel-indexed register port. The host writes a byte to transmit, reads a received byte, reads a status word and programs the channel's rate divisor. A channel's bit time is 256·(D+1) clocks, where D is its divisor. The rate ceiling is therefore the clock frequency divided by 256, and any slower standard rate down to 1200 baud is reached by choosing D.

Top module: `tdm_uart`

## Requirements
- R1: The engine visits channel slots 0,1,…,NCH-1 and then wraps to 0, advancing exactly one slot per clock, so all channels run at the same time.
- R2: Each channel has a divisor D, written and read at register address 2, with reset value 0. Its bit time is 256·(D+1) clocks, independent of the other channels.
- R3: Writing a byte to address 0 while the channel's transmit holding register is empty sends one frame: a low start bit, eight data bits least-significant bit first, and a high stop bit, each lasting one bit time. The idle line is high.
- R4: Status at address 1 has bit 0 = receive ready, bit 1 = transmit holding empty, bit 2 = framing error. After reset every channel reads 3'b010 and every serial output is high.
- R5: The receiver starts on a falling edge of its line and confirms the start bit half a bit later. A low pulse shorter than half a bit is ignored and sets no ready flag. Data bits are sampled at mid-bit, and a completed character is placed in the receive holding register with ready set.
- R6: A host read of address 0 with the read strobe returns the received byte in bits 7:0 and clears ready and framing error.
- R7: A stop bit sampled low sets the framing error flag together with ready.
- R8: The flow-control output of a channel is high while its receive holding register is empty and low while it holds an unread character.
- R9: A write to address 0 while the transmit holding register is still full is ignored: that byte is never sent.
- R10: While a channel's clear-to-send input is low, a pending character is not started. A character already in progress completes. A pending character starts once the input returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_i | input | NCH (16) | Serial receive line, one per channel |
| cts_i | input | NCH (16) | Clear-to-send, high allows a new character to start |
| txd_o | output | NCH (16) | Serial transmit line, one per channel |
| rts_o | output | NCH (16) | Ready-to-receive, high while the receive holding register is empty |
| host_ch | input | CH_W (4) | Channel selected by the host access |
| host_addr | input | 2 | 0 data, 1 status, 2 divisor |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe; consumes the received byte when address is 0 |
| host_wdata | input | DIV_W (16) | Write data |
| host_rdata | output | DIV_W (16) | Read data for the selected channel and address, combinational |

## Verification
Host register results are due in the clock after the strobe, so the bench drives strobes at the falling edge and reads the status word one falling edge later. A written byte's start bit appears within one oversample tick, at most 16·(D+1) clocks after the write. The bench therefore does not predict that cycle: it waits for the observed falling edge on the line and samples every later bit at its middle. The receive ready flag and flow-control change occur at mid-stop-bit, so the bench reads status only after it has finished driving the complete stop bit plus a whole idle bit. Checks that something must not happen watch the line over more than one full character time.

// File: rtl/tdm_uart_pkg.sv
package tdm_uart_pkg;
  localparam int DIV_W = 16;
  localparam int OSR_W = 4;              // 16x oversampling
  localparam logic [OSR_W-1:0] MID = 4'd8;
  localparam logic [3:0] LAST_BIT = 4'd9; // start + 8 data + stop, counted from 0

  typedef struct packed {
    logic [DIV_W-1:0] os_cnt;
    logic             tx_busy;
    logic [OSR_W-1:0] tx_ph;
    logic [3:0]       tx_bit;
    logic [9:0]       tx_sh;
    logic             rx_busy;
    logic             rx_last;
    logic [OSR_W-1:0] rx_ph;
    logic [3:0]       rx_bit;
    logic [7:0]       rx_sh;
  } ctx_t;

  localparam ctx_t CTX_RST = '{tx_sh: '1, rx_last: 1'b1, default: '0};

  // an oversample tick fires on the visit where the stored count is zero
  function automatic logic os_tick(input logic [DIV_W-1:0] cnt);
    return cnt == '0;
  endfunction

  function automatic logic [DIV_W-1:0] os_next(input logic [DIV_W-1:0] cnt,
                                              input logic [DIV_W-1:0] div);
    return (cnt == '0) ? div : cnt - 1'b1;
  endfunction

  // shift-out image, bit 0 leaves first
  function automatic logic [9:0] tx_frame(input logic [7:0] d);
    return {1'b1, d, 1'b0};
  endfunction
endpackage

// File: rtl/tdm_uart_sync.sv
module tdm_uart_sync #(
  parameter int   W       = 16,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta, held;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= RST_VAL;
        held <= RST_VAL;
      end else begin
        meta <= d[i];
        held <= meta;
      end
    end
    assign q[i] = held;
  end
endmodule

// File: rtl/tdm_uart_slot.sv
module tdm_uart_slot #(
  parameter int N = 16,
  parameter int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] slot
);
  localparam logic [W-1:0] LAST = W'(N - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             slot <= '0;
    else if (slot == LAST)  slot <= '0;
    else                    slot <= slot + 1'b1;
  end

  // R1: rotation wraps after the last slot
  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == LAST) |=> (slot == '0));
  // R1: otherwise exactly one step per clock
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (slot != LAST) |=> (slot == $past(slot) + 1'b1));
endmodule

// File: rtl/tdm_uart_engine.sv
module tdm_uart_engine
  import tdm_uart_pkg::*;
(
  input  ctx_t             cur,
  input  logic [DIV_W-1:0] div,
  input  logic             tx_full,
  input  logic [7:0]       tx_data,
  input  logic             cts,
  input  logic             rxd,
  input  logic             txd_cur,
  output ctx_t             nxt,
  output logic             txd_nxt,
  output logic             tx_take,
  output logic             rx_done,
  output logic [7:0]       rx_byte,
  output logic             rx_ferr
);
  logic             tick;
  logic [OSR_W-1:0] tph, rph;

  always_comb begin
    nxt     = cur;
    txd_nxt = txd_cur;
    tx_take = 1'b0;
    rx_done = 1'b0;
    rx_byte = cur.rx_sh;
    rx_ferr = 1'b0;
    tick    = os_tick(cur.os_cnt);
    tph     = cur.tx_ph + 1'b1;
    rph     = cur.rx_ph + 1'b1;
    nxt.os_cnt = os_next(cur.os_cnt, div);

    if (tick) begin
      // transmitter: new characters start only at a boundary with cts high
      if (!cur.tx_busy) begin
        txd_nxt = 1'b1;
        if (tx_full && cts) begin
          nxt.tx_busy = 1'b1;
          nxt.tx_sh   = tx_frame(tx_data);
          nxt.tx_ph   = '0;
          nxt.tx_bit  = '0;
          tx_take     = 1'b1;
          txd_nxt     = 1'b0;
        end
      end else begin
        nxt.tx_ph = tph;
        if (tph == '0) begin
          if (cur.tx_bit == LAST_BIT) begin
            nxt.tx_busy = 1'b0;
            txd_nxt     = 1'b1;
          end else begin
            nxt.tx_sh  = {1'b1, cur.tx_sh[9:1]};
            nxt.tx_bit = cur.tx_bit + 1'b1;
            txd_nxt    = cur.tx_sh[1];
          end
        end
      end

      // receiver: edge hunt, mid-bit confirm, mid-bit sampling
      nxt.rx_last = rxd;
      if (!cur.rx_busy) begin
        if (cur.rx_last && !rxd) begin
          nxt.rx_busy = 1'b1;
          nxt.rx_ph   = '0;
          nxt.rx_bit  = '0;
        end
      end else begin
        nxt.rx_ph = rph;
        if (rph == MID) begin
          nxt.rx_bit = cur.rx_bit + 1'b1;
          if (cur.rx_bit == '0) begin
            if (rxd) nxt.rx_busy = 1'b0;     // false start
          end else if (cur.rx_bit == LAST_BIT) begin
            nxt.rx_busy = 1'b0;
            rx_done     = 1'b1;
            rx_ferr     = !rxd;
          end else begin
            nxt.rx_sh = {rxd, cur.rx_sh[7:1]};
          end
        end
      end
    end
  end
endmodule

// File: rtl/tdm_uart.sv
module tdm_uart
  import tdm_uart_pkg::*;
#(
  parameter int NCH  = 16,
  parameter int CH_W = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   rxd_i,
  input  logic [NCH-1:0]   cts_i,
  output logic [NCH-1:0]   txd_o,
  output logic [NCH-1:0]   rts_o,
  input  logic [CH_W-1:0]  host_ch,
  input  logic [1:0]       host_addr,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [DIV_W-1:0] host_wdata,
  output logic [DIV_W-1:0] host_rdata
);
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DIV  = 2'd2;

  logic [CH_W-1:0]             slot;
  ctx_t                        ctx_ram [NCH];
  logic [NCH-1:0][DIV_W-1:0]   div_q;
  logic [NCH-1:0][7:0]         tx_hold, rx_hold;
  logic [NCH-1:0]              tx_full, rx_full, ferr, txd_q;
  logic [NCH-1:0]              rxd_s, cts_s;

  // named engine events
  ctx_t       e_nxt;
  logic       e_txd, e_tx_take, e_rx_done, e_ferr;
  logic [7:0] e_rx_byte;
  logic       host_data_wr, host_data_rd;

  assign host_data_wr = host_wr && (host_addr == A_DATA);
  assign host_data_rd = host_rd && (host_addr == A_DATA);

  tdm_uart_sync #(.W(NCH), .RST_VAL(1'b1)) u_rx_sync (.clk(clk), .rst_n(rst_n), .d(rxd_i), .q(rxd_s));
  tdm_uart_sync #(.W(NCH), .RST_VAL(1'b0)) u_cts_sync (.clk(clk), .rst_n(rst_n), .d(cts_i), .q(cts_s));
  tdm_uart_slot #(.N(NCH), .W(CH_W))       u_slot (.clk(clk), .rst_n(rst_n), .slot(slot));

  tdm_uart_engine u_eng (
    .cur(ctx_ram[slot]), .div(div_q[slot]), .tx_full(tx_full[slot]),
    .tx_data(tx_hold[slot]), .cts(cts_s[slot]), .rxd(rxd_s[slot]),
    .txd_cur(txd_q[slot]), .nxt(e_nxt), .txd_nxt(e_txd), .tx_take(e_tx_take),
    .rx_done(e_rx_done), .rx_byte(e_rx_byte), .rx_ferr(e_ferr)
  );

  // context memory: one read-modify-write per clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) ctx_ram[i] <= CTX_RST;
    end else begin
      ctx_ram[slot] <= e_nxt;
    end
  end

  // holding registers, flags and line outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      tx_hold <= '0;
      rx_hold <= '0;
      tx_full <= '0;
      rx_full <= '0;
      ferr    <= '0;
      txd_q   <= '1;
    end else begin
      txd_q[slot] <= e_txd;
      if (host_data_rd) begin
        rx_full[host_ch] <= 1'b0;
        ferr[host_ch]    <= 1'b0;
      end
      if (e_rx_done) begin            // a new character wins over a same-cycle read
        rx_hold[slot] <= e_rx_byte;
        rx_full[slot] <= 1'b1;
        ferr[slot]    <= e_ferr;
      end
      if (e_tx_take) tx_full[slot] <= 1'b0;
      if (host_data_wr && !tx_full[host_ch]) begin
        tx_full[host_ch] <= 1'b1;
        tx_hold[host_ch] <= host_wdata[7:0];
      end
      if (host_wr && (host_addr == A_DIV)) div_q[host_ch] <= host_wdata;
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      A_DATA:  host_rdata[7:0] = rx_hold[host_ch];
      A_STAT:  host_rdata[2:0] = {ferr[host_ch], !tx_full[host_ch], rx_full[host_ch]};
      A_DIV:   host_rdata      = div_q[host_ch];
      default: host_rdata      = '0;
    endcase
  end

  assign txd_o = txd_q;
  assign rts_o = ~rx_full;

  // R3: taking a character drives the start bit on the next cycle
  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    e_tx_take |=> !txd_o[$past(slot)]);
  // R5: a completed character leaves the channel ready
  a_r5_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
    e_rx_done |=> rx_full[$past(slot)]);
  // R7: a low stop bit leaves the framing flag set
  a_r7_ferr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (e_rx_done && e_ferr) |=> ferr[$past(slot)]);
  // R8: consuming the character raises flow control
  a_r8_rts_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (host_data_rd && !(e_rx_done && (slot == host_ch))) |=> rts_o[$past(host_ch)]);
  // R9: a write into a full holding register changes nothing
  a_r9_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (host_data_wr && tx_full[host_ch]) |=> $stable(tx_hold));
  // R10: a character is never started while clear-to-send is low
  a_r10_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
    e_tx_take |-> cts_s[slot]);
endmodule

// File: tb/sim_tdm_uart.sv
module sim_tdm_uart;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;
  localparam int BT0 = 256;   // bit time at divisor 0
  localparam int BT1 = 512;   // bit time at divisor 1

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH-1:0]    rx_drv = '1;
  logic [NCH-1:0]    cts_drv = '1;
  logic [NCH-1:0]    txd_o, rts_o;
  logic [3:0]        host_ch = '0;
  logic [1:0]        host_addr = '0;
  logic              host_wr = 1'b0, host_rd = 1'b0;
  logic [15:0]       host_wdata = '0;
  logic [15:0]       host_rdata;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_uart u0 (
    .clk(clk), .rst_n(rst_n), .rxd_i(rx_drv), .cts_i(cts_drv), .txd_o(txd_o),
    .rts_o(rts_o), .host_ch(host_ch), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    host_ch = 4'(ch); host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input int ch, input logic [1:0] a, input logic strobe, output logic [15:0] d);
    @(negedge clk);
    host_ch = 4'(ch); host_addr = a; host_rd = strobe;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic cap_tx(input int ch, input int bt, output logic [7:0] d, output logic ok);
    int n = 0;
    d = '0;
    ok = 1'b0;
    while (txd_o[ch] !== 1'b0 && n < 20000) begin @(negedge clk); n++; end
    repeat (bt/2) @(negedge clk);
    ok = (txd_o[ch] == 1'b0);
    for (int i = 0; i < 8; i++) begin
      repeat (bt) @(negedge clk);
      d[i] = txd_o[ch];
    end
    repeat (bt) @(negedge clk);
    ok = ok & txd_o[ch];
  endtask

  task automatic drv_rx(input int ch, input logic [7:0] d, input logic stop, input int bt);
    @(negedge clk);
    rx_drv[ch] = 1'b0;
    repeat (bt) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_drv[ch] = d[i];
      repeat (bt) @(negedge clk);
    end
    rx_drv[ch] = stop;
    repeat (bt) @(negedge clk);
    rx_drv[ch] = 1'b1;
    repeat (bt) @(negedge clk);
  endtask

  // counts low samples on one line over a window
  task automatic quiet(input int ch, input int len, output int lows);
    lows = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (txd_o[ch] == 1'b0) lows++;
    end
  endtask

  task automatic t_reset;
    logic [15:0] d;
    chk("R4 reset tx lines high", int'(txd_o), 16'hffff);
    chk("R8 reset flow-control high", int'(rts_o), 16'hffff);
    rd(0, 2'd1, 1'b0, d);
    chk("R4 reset status ch0", int'(d[2:0]), 3'b010);
    rd(15, 2'd2, 1'b0, d);
    chk("R2 reset divisor ch15", int'(d), 0);
  endtask

  task automatic t_tx_basic;
    logic [7:0] d; logic ok;
    wr(3, 2'd0, 16'h00a5);
    cap_tx(3, BT0, d, ok);
    chk("R3 tx data ch3", int'(d), 8'ha5);
    chk("R3 tx start/stop ch3", int'(ok), 1);
  endtask

  task automatic t_rates;
    logic [7:0] d5, d9; logic ok5, ok9; logic [15:0] r;
    wr(5, 2'd2, 16'd1);
    rd(5, 2'd2, 1'b0, r);
    chk("R2 divisor readback ch5", int'(r), 1);
    wr(5, 2'd0, 16'h003c);
    wr(9, 2'd0, 16'h00c3);
    fork
      cap_tx(5, BT1, d5, ok5);
      cap_tx(9, BT0, d9, ok9);
    join
    chk("R2 R1 slow channel data", int'(d5), 8'h3c);
    chk("R2 R1 slow channel framing", int'(ok5), 1);
    chk("R2 R1 fast channel data", int'(d9), 8'hc3);
    chk("R2 R1 fast channel framing", int'(ok9), 1);
  endtask

  task automatic t_rx_basic;
    logic [15:0] r;
    drv_rx(2, 8'h5a, 1'b1, BT0);
    rd(2, 2'd1, 1'b0, r);
    chk("R5 rx ready status", int'(r[2:0]), 3'b011);
    chk("R8 flow-control low while full", int'(rts_o[2]), 0);
    rd(2, 2'd0, 1'b1, r);
    chk("R5 R6 rx data", int'(r[7:0]), 8'h5a);
    rd(2, 2'd1, 1'b0, r);
    chk("R6 ready cleared by read", int'(r[2:0]), 3'b010);
    chk("R8 flow-control high after read", int'(rts_o[2]), 1);
  endtask

  task automatic t_ferr;
    logic [15:0] r;
    drv_rx(7, 8'h81, 1'b0, BT0);
    rd(7, 2'd1, 1'b0, r);
    chk("R7 framing error status", int'(r[2:0]), 3'b111);
    rd(7, 2'd0, 1'b1, r);
    chk("R7 data kept on framing error", int'(r[7:0]), 8'h81);
    rd(7, 2'd1, 1'b0, r);
    chk("R6 framing flag cleared by read", int'(r[2:0]), 3'b010);
  endtask

  task automatic t_glitch;
    logic [15:0] r;
    @(negedge clk);
    rx_drv[11] = 1'b0;
    repeat (40) @(negedge clk);
    rx_drv[11] = 1'b1;
    repeat (3000) @(negedge clk);
    rd(11, 2'd1, 1'b0, r);
    chk("R5 short pulse ignored", int'(r[2:0]), 3'b010);
    chk("R8 flow-control unchanged by pulse", int'(rts_o[11]), 1);
  endtask

  task automatic t_cts;
    logic [7:0] d; logic ok; logic [15:0] r; int lows;
    @(negedge clk);
    cts_drv[4] = 1'b0;
    repeat (10) @(negedge clk);
    wr(4, 2'd0, 16'h0077);
    quiet(4, 3000, lows);
    chk("R10 held while clear-to-send low", lows, 0);
    rd(4, 2'd1, 1'b0, r);
    chk("R10 holding still full", int'(r[1]), 0);
    wr(4, 2'd0, 16'h0011);
    @(negedge clk);
    cts_drv[4] = 1'b1;
    cap_tx(4, BT0, d, ok);
    chk("R10 R9 first byte sent after release", int'(d), 8'h77);
    chk("R10 framing after release", int'(ok), 1);
    quiet(4, 3000, lows);
    chk("R9 dropped byte never sent", lows, 0);
    rd(4, 2'd1, 1'b0, r);
    chk("R9 holding empty", int'(r[1]), 1);
    wr(4, 2'd0, 16'h000f);
    fork
      cap_tx(4, BT0, d, ok);
      begin
        wait (txd_o[4] == 1'b0);
        @(negedge clk);
        cts_drv[4] = 1'b0;
      end
    join
    chk("R10 character in progress completes", int'(d), 8'h0f);
    chk("R10 in-progress framing", int'(ok), 1);
    cts_drv[4] = 1'b1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_tx_basic();
    t_rates();
    t_rx_basic();
    t_ferr();
    t_glitch();
    t_cts();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule